// File: doc/BRIEF.md
# Readout Protection Level Controller

This block holds the chip's readout-protection level and enforces what that level allows. While reset is asserted it decodes an 8-bit protection code, as stored in non-volatile configuration, into one of three levels. Two code values are reserved: one gives the open level and one gives the locked level. Every other value gives the middle, protected level. After reset it gates each memory access request from the bus side. Each request goes to user flash, SRAM or the backup registers. The block grants the request or blocks it, and it raises a one-cycle hard-fault pulse when the level's policy refuses the access.

The same block enables or disables the debug port and tells the boot logic whether the selected boot source is allowed. It also accepts requests to move to a new level, written as a new protection code. Tightening moves take effect at once. A move from the protected level back to the open level first runs a mass-erase sequence of user flash, backup registers and the protected SRAM section. The new level applies only when that sequence completes. The locked level can never be left. A request that is refused leaves the level untouched and sets a sticky error flag.

Top module: `rdp_ctrl`

## Requirements
- R1: While `rst` is high the level is loaded from `opt_byte_i`: 0xAA gives level 0, 0xCC gives level 2, any other value gives level 1 (`level_o` = 0, 1, 2). Changing `opt_byte_i` after reset has no effect on the level.
- R2: Access results are registered and appear one cycle after `acc_req_i`. Region codes are 0 = user flash, 1 = SRAM, 2 = backup registers, and 3 is unmapped. A request to region 3 is always blocked. At level 0 every request to a mapped region is granted, whatever the debugger status and boot source.
- R3: At level 1, a request is blocked and `fault_o` pulses for exactly one cycle when `dbg_attached_i` is high or `boot_sel_i` is not 0. Boot codes are 0 = user flash, 1 = system memory, 2 = RAM, 3 = reserved. Otherwise the request is granted.
- R4: At level 2, `dbg_en_o` is 0 and the debugger status is ignored. `boot_ok_o` is 0 whenever `boot_sel_i` is not 0, and a request under such a boot source is blocked with a fault. At levels 0 and 1, `dbg_en_o` and `boot_ok_o` are 1.
- R5: A change request whose code decodes to a higher level (0 to 1, 0 to 2, 1 to 2) updates `level_o` at the clock edge that samples it. A request for the current level is a no-op and sets no error.
- R6: A request from level 1 to level 0 starts an erase sequence. `erase_busy_o` is high for one busy cycle, then for `ERASE_CYCLES` cycles with `mass_erase_o` high, then for one done cycle, and `level_o` becomes 0 at the end of the done cycle. Until then `level_o` stays 1. Accesses made while `erase_busy_o` is high are blocked without a fault.
- R7: At level 2 every change request is ignored and sets `err_o`.
- R8: A change request made while the erase sequence runs is ignored and sets `err_o`. `err_o` stays high until reset.
- R9: `acc_grant_o` and `acc_block_o` are never high together, and `fault_o` is only high together with `acc_block_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the protection code is sampled while it is high |
| opt_byte_i | input | 8 | Stored protection code |
| dbg_attached_i | input | 1 | A debugger is connected |
| boot_sel_i | input | 2 | Selected boot source (0 user flash, 1 system memory, 2 RAM, 3 reserved) |
| acc_req_i | input | 1 | Memory access request, one cycle per access |
| acc_region_i | input | 2 | Target region of the access (0 flash, 1 SRAM, 2 backup, 3 unmapped) |
| chg_req_i | input | 1 | Level change request |
| chg_byte_i | input | 8 | Requested new protection code |
| level_o | output | 2 | Current protection level |
| acc_grant_o | output | 1 | Access granted |
| acc_block_o | output | 1 | Access blocked |
| fault_o | output | 1 | One-cycle hard-fault pulse on a policy refusal |
| dbg_en_o | output | 1 | Debug port enable |
| boot_ok_o | output | 1 | Selected boot source is allowed |
| mass_erase_o | output | 1 | Mass-erase command to the memories |
| erase_busy_o | output | 1 | Erase sequence in progress |
| err_o | output | 1 | Sticky flag for a refused change request |

## Verification
The assertions take for granted that `rst` is held high for at least one clock at start. They also assume that access and change requests are single-cycle pulses, and that the debugger status and boot selection are steady around each access. The stimulus drives every input on the falling clock edge. It changes the boot source and debugger status only between accesses, usually across a reset, so that each access is judged against one settled policy. Change requests during the erase sequence are issued on purpose, to reach the rule for refused requests.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

  typedef enum logic [1:0] {
    LVL_OPEN   = 2'd0,
    LVL_GUARD  = 2'd1,
    LVL_LOCKED = 2'd2
  } lvl_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_BUSY  = 2'd1,
    SEQ_ERASE = 2'd2,
    SEQ_DONE  = 2'd3
  } seq_e;

  localparam logic [1:0] BOOT_USER_FLASH = 2'd0;
  localparam logic [1:0] REGION_NONE     = 2'd3;

  function automatic lvl_e code_to_level(input logic [7:0] code,
                                         input logic [7:0] open_code,
                                         input logic [7:0] lock_code);
    if (code == open_code)      return LVL_OPEN;
    else if (code == lock_code) return LVL_LOCKED;
    else                        return LVL_GUARD;
  endfunction

endpackage

// File: rtl/rdp_erase_seq.sv
module rdp_erase_seq
  import rdp_pkg::*;
#(
  parameter int ERASE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic erase_o,
  output logic done_o
);

  localparam int CW = (ERASE_CYCLES > 1) ? $clog2(ERASE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(ERASE_CYCLES - 1);

  seq_e          st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        SEQ_IDLE: if (start_i) st_q <= SEQ_BUSY;
        SEQ_BUSY: begin
          st_q  <= SEQ_ERASE;
          cnt_q <= '0;
        end
        SEQ_ERASE: begin
          if (cnt_q == LAST) st_q <= SEQ_DONE;
          else               cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q != SEQ_IDLE);
  assign erase_o = (st_q == SEQ_ERASE);
  assign done_o  = (st_q == SEQ_DONE);

endmodule

// File: rtl/rdp_level_ctrl.sv
module rdp_level_ctrl
  import rdp_pkg::*;
#(
  parameter logic [7:0] OPEN_CODE = 8'hAA,
  parameter logic [7:0] LOCK_CODE = 8'hCC
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] opt_byte_i,
  input  logic [1:0] boot_sel_i,
  input  logic       chg_req_i,
  input  logic [7:0] chg_byte_i,
  input  logic       seq_busy_i,
  input  logic       seq_done_i,
  output lvl_e       lvl_o,
  output logic       erase_start_o,
  output logic       err_o,
  output logic       dbg_en_o,
  output logic       boot_ok_o
);

  lvl_e lvl_q, lvl_d, tgt, boot_lvl;
  logic refuse;
  logic err_q, dbg_en_q, boot_ok_q;

  assign tgt      = code_to_level(chg_byte_i, OPEN_CODE, LOCK_CODE);
  assign boot_lvl = code_to_level(opt_byte_i, OPEN_CODE, LOCK_CODE);

  always_comb begin
    lvl_d         = lvl_q;
    erase_start_o = 1'b0;
    refuse        = 1'b0;
    if (chg_req_i) begin
      if (seq_busy_i || lvl_q == LVL_LOCKED)         refuse = 1'b1;
      else if (tgt == lvl_q)                         lvl_d  = lvl_q;
      else if (lvl_q == LVL_GUARD && tgt == LVL_OPEN) erase_start_o = 1'b1;
      else                                           lvl_d  = tgt;
    end
    if (seq_done_i) lvl_d = LVL_OPEN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q     <= boot_lvl;
      err_q     <= 1'b0;
      dbg_en_q  <= (boot_lvl != LVL_LOCKED);
      boot_ok_q <= !(boot_lvl == LVL_LOCKED && boot_sel_i != BOOT_USER_FLASH);
    end else begin
      lvl_q     <= lvl_d;
      err_q     <= err_q | refuse;
      dbg_en_q  <= (lvl_d != LVL_LOCKED);
      boot_ok_q <= !(lvl_d == LVL_LOCKED && boot_sel_i != BOOT_USER_FLASH);
    end
  end

  assign lvl_o     = lvl_q;
  assign err_o     = err_q;
  assign dbg_en_o  = dbg_en_q;
  assign boot_ok_o = boot_ok_q;

endmodule

// File: rtl/rdp_access_gate.sv
module rdp_access_gate
  import rdp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  lvl_e       lvl_i,
  input  logic       dbg_i,
  input  logic [1:0] boot_sel_i,
  input  logic       seq_busy_i,
  input  logic       req_i,
  input  logic [1:0] region_i,
  output logic       grant_o,
  output logic       block_o,
  output logic       fault_o
);

  logic foreign_boot, deny, allow;
  logic grant_q, block_q, fault_q;

  assign foreign_boot = (boot_sel_i != BOOT_USER_FLASH);

  always_comb begin
    case (lvl_i)
      LVL_GUARD:  deny = dbg_i | foreign_boot;
      LVL_LOCKED: deny = foreign_boot;
      default:    deny = 1'b0;
    endcase
  end

  assign allow = !seq_busy_i && !deny && (region_i != REGION_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= 1'b0;
      block_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      grant_q <= req_i & allow;
      block_q <= req_i & !allow;
      fault_q <= req_i & !seq_busy_i & deny;
    end
  end

  assign grant_o = grant_q;
  assign block_o = block_q;
  assign fault_o = fault_q;

endmodule

// File: rtl/rdp_ctrl.sv
module rdp_ctrl
  import rdp_pkg::*;
#(
  parameter logic [7:0] OPEN_CODE    = 8'hAA,
  parameter logic [7:0] LOCK_CODE    = 8'hCC,
  parameter int         ERASE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] opt_byte_i,
  input  logic       dbg_attached_i,
  input  logic [1:0] boot_sel_i,
  input  logic       acc_req_i,
  input  logic [1:0] acc_region_i,
  input  logic       chg_req_i,
  input  logic [7:0] chg_byte_i,
  output logic [1:0] level_o,
  output logic       acc_grant_o,
  output logic       acc_block_o,
  output logic       fault_o,
  output logic       dbg_en_o,
  output logic       boot_ok_o,
  output logic       mass_erase_o,
  output logic       erase_busy_o,
  output logic       err_o
);

  lvl_e lvl;
  logic seq_busy, seq_done, seq_start;

  rdp_level_ctrl #(
    .OPEN_CODE(OPEN_CODE),
    .LOCK_CODE(LOCK_CODE)
  ) u_level (
    .clk          (clk),
    .rst          (rst),
    .opt_byte_i   (opt_byte_i),
    .boot_sel_i   (boot_sel_i),
    .chg_req_i    (chg_req_i),
    .chg_byte_i   (chg_byte_i),
    .seq_busy_i   (seq_busy),
    .seq_done_i   (seq_done),
    .lvl_o        (lvl),
    .erase_start_o(seq_start),
    .err_o        (err_o),
    .dbg_en_o     (dbg_en_o),
    .boot_ok_o    (boot_ok_o)
  );

  rdp_erase_seq #(
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start_i(seq_start),
    .busy_o (seq_busy),
    .erase_o(mass_erase_o),
    .done_o (seq_done)
  );

  rdp_access_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .lvl_i     (lvl),
    .dbg_i     (dbg_attached_i),
    .boot_sel_i(boot_sel_i),
    .seq_busy_i(seq_busy),
    .req_i     (acc_req_i),
    .region_i  (acc_region_i),
    .grant_o   (acc_grant_o),
    .block_o   (acc_block_o),
    .fault_o   (fault_o)
  );

  assign level_o      = lvl;
  assign erase_busy_o = seq_busy;

endmodule

// File: rtl/rdp_ctrl_chk.sv
module rdp_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       acc_req_i,
  input logic [1:0] acc_region_i,
  input logic [1:0] level_o,
  input logic       acc_grant_o,
  input logic       acc_block_o,
  input logic       fault_o,
  input logic       dbg_en_o,
  input logic       mass_erase_o,
  input logic       erase_busy_o,
  input logic       err_o
);

  a_r9_grant_block_excl: assert property (@(posedge clk) disable iff (rst)
    !(acc_grant_o && acc_block_o));

  a_r9_fault_with_block: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> acc_block_o);

  a_r2_open_grants: assert property (@(posedge clk) disable iff (rst)
    (acc_req_i && level_o == 2'd0 && !erase_busy_o && acc_region_i != 2'd3) |=> acc_grant_o);

  a_r4_locked_no_debug: assert property (@(posedge clk) disable iff (rst)
    (level_o == 2'd2) |-> !dbg_en_o);

  a_r7_locked_permanent: assert property (@(posedge clk) disable iff (rst)
    (level_o == 2'd2) |=> (level_o == 2'd2));

  a_r6_open_only_after_erase: assert property (@(posedge clk) disable iff (rst)
    (level_o == 2'd1) |=> (level_o != 2'd0 || $past(erase_busy_o)));

  a_r6_erase_at_guard: assert property (@(posedge clk) disable iff (rst)
    mass_erase_o |-> (level_o == 2'd1 && erase_busy_o));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

endmodule

bind rdp_ctrl rdp_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .acc_req_i   (acc_req_i),
  .acc_region_i(acc_region_i),
  .level_o     (level_o),
  .acc_grant_o (acc_grant_o),
  .acc_block_o (acc_block_o),
  .fault_o     (fault_o),
  .dbg_en_o    (dbg_en_o),
  .mass_erase_o(mass_erase_o),
  .erase_busy_o(erase_busy_o),
  .err_o       (err_o)
);

// File: tb/tb_rdp_ctrl.sv
`timescale 1ns/1ps
module tb_rdp_ctrl;

  localparam int ERASE_N = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opt_byte = 8'h55;
  logic       dbg = 1'b0;
  logic [1:0] boot = 2'd0;
  logic       acc_req = 1'b0;
  logic [1:0] region = 2'd0;
  logic       chg_req = 1'b0;
  logic [7:0] chg_byte = 8'h00;
  logic [1:0] level;
  logic       grant, block, fault, dbg_en, boot_ok, erase, busy, err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rdp_ctrl #(.ERASE_CYCLES(ERASE_N)) dut (
    .clk(clk), .rst(rst), .opt_byte_i(opt_byte), .dbg_attached_i(dbg),
    .boot_sel_i(boot), .acc_req_i(acc_req), .acc_region_i(region),
    .chg_req_i(chg_req), .chg_byte_i(chg_byte), .level_o(level),
    .acc_grant_o(grant), .acc_block_o(block), .fault_o(fault),
    .dbg_en_o(dbg_en), .boot_ok_o(boot_ok), .mass_erase_o(erase),
    .erase_busy_o(busy), .err_o(err)
  );

  // {code[7:0], dbg, boot[1:0], region[1:0], exp_grant, exp_fault}
  localparam int NV = 10;
  localparam logic [14:0] VEC [NV] = '{
    {8'hAA, 1'b1, 2'd2, 2'd0, 1'b1, 1'b0},
    {8'hAA, 1'b0, 2'd0, 2'd2, 1'b1, 1'b0},
    {8'h55, 1'b0, 2'd0, 2'd1, 1'b1, 1'b0},
    {8'h55, 1'b1, 2'd0, 2'd0, 1'b0, 1'b1},
    {8'h55, 1'b0, 2'd1, 2'd2, 1'b0, 1'b1},
    {8'h55, 1'b0, 2'd2, 2'd0, 1'b0, 1'b1},
    {8'hCC, 1'b1, 2'd0, 2'd0, 1'b1, 1'b0},
    {8'hCC, 1'b0, 2'd2, 2'd1, 1'b0, 1'b1},
    {8'h00, 1'b0, 2'd0, 2'd3, 1'b0, 1'b0},
    {8'hFF, 1'b0, 2'd0, 2'd0, 1'b1, 1'b0}
  };

  function automatic logic [1:0] lvl_of(input logic [7:0] c);
    if (c == 8'hAA) return 2'd0;
    if (c == 8'hCC) return 2'd2;
    return 2'd1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] code);
    rst = 1'b1;
    opt_byte = code;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_access(input logic [1:0] r);
    acc_req = 1'b1;
    region = r;
    @(negedge clk);
    acc_req = 1'b0;
  endtask

  task automatic do_change(input logic [7:0] c);
    chg_req = 1'b1;
    chg_byte = c;
    @(negedge clk);
    chg_req = 1'b0;
  endtask

  initial begin
    int cyc;
    int n_er;
    @(negedge clk);

    // Reset state
    do_reset(8'h55);
    chk("R1 reset level", level, 2'd1);
    chk("R9 reset grant", grant, 0);
    chk("R9 reset block", block, 0);
    chk("R3 reset fault", fault, 0);
    chk("R8 reset err", err, 0);
    opt_byte = 8'hAA;
    @(negedge clk);
    chk("R1 code ignored after reset", level, 2'd1);

    // Access policy table
    for (int i = 0; i < NV; i++) begin
      logic [14:0] v;
      v = VEC[i];
      dbg = v[6];
      boot = v[5:4];
      do_reset(v[14:7]);
      chk("R1 decoded level", level, lvl_of(v[14:7]));
      do_access(v[3:2]);
      chk("R2 R3 R4 grant", grant, v[1]);
      chk("R9 block", block, !v[1]);
      chk("R3 R4 fault", fault, v[0]);
      @(negedge clk);
      chk("R3 fault one cycle", fault, 0);
    end
    dbg = 1'b0;
    boot = 2'd0;

    // Debug and boot gating
    do_reset(8'hAA);
    @(negedge clk);
    chk("R4 dbg_en at level 0", dbg_en, 1);
    chk("R4 boot_ok at level 0", boot_ok, 1);
    boot = 2'd2;
    @(negedge clk);
    chk("R4 boot_ok level 0 ram boot", boot_ok, 1);
    boot = 2'd0;

    // Upward transitions
    do_change(8'h31);
    chk("R5 level 0 to 1", level, 2'd1);
    chk("R5 no err on legal move", err, 0);
    do_change(8'h77);
    chk("R5 same level no-op", level, 2'd1);
    chk("R5 same level no err", err, 0);
    chk("R5 same level no erase", busy, 0);
    do_change(8'hCC);
    chk("R5 level 1 to 2", level, 2'd2);
    chk("R4 dbg_en off at level 2", dbg_en, 0);
    boot = 2'd1;
    @(negedge clk);
    chk("R4 boot_ok off for system memory", boot_ok, 0);
    boot = 2'd0;
    @(negedge clk);
    chk("R4 boot_ok on for user flash", boot_ok, 1);

    // Level 2 is permanent
    do_change(8'hAA);
    chk("R7 locked stays", level, 2'd2);
    chk("R7 err set", err, 1);
    chk("R7 no erase", busy, 0);
    do_change(8'h55);
    chk("R7 locked stays again", level, 2'd2);
    repeat (3) @(negedge clk);
    chk("R8 err sticky", err, 1);

    do_reset(8'hAA);
    do_change(8'hCC);
    chk("R5 level 0 to 2", level, 2'd2);

    // Regression with mass erase
    do_reset(8'h55);
    do_change(8'hAA);
    chk("R6 busy after request", busy, 1);
    chk("R6 level held during busy", level, 2'd1);
    chk("R6 no erase in busy cycle", erase, 0);
    cyc = 0;
    n_er = 0;
    while (level != 2'd0 && cyc < 20) begin
      @(negedge clk);
      cyc++;
      if (erase) n_er++;
    end
    chk("R6 erase cycle count", n_er, ERASE_N);
    chk("R6 level 0 after done", cyc, ERASE_N + 2);
    chk("R6 idle at level 0", busy, 0);
    chk("R6 dbg_en at level 0", dbg_en, 1);

    // Access and request during the sequence
    do_reset(8'h55);
    do_change(8'hAA);
    do_access(2'd0);
    chk("R6 access blocked while erasing", block, 1);
    chk("R6 no grant while erasing", grant, 0);
    chk("R6 no fault while erasing", fault, 0);
    do_change(8'hCC);
    chk("R8 request during erase refused", err, 1);
    repeat (ERASE_N + 4) @(negedge clk);
    chk("R8 level after refused request", level, 2'd0);
    chk("R8 err still set", err, 1);
    do_access(2'd1);
    chk("R2 grant after regression", grant, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule